// File: doc/BRIEF.md
# Prescaled Real-Time Counter with Cross-Domain Control

This block is a 32-bit counter that advances in a slow real-time clock domain. Its control and compare registers sit in a fast bus clock domain. A small register port lets software pick a power-of-two prescaler, set a compare value, choose whether the counter wraps to zero when it reaches that value, and start or stop counting. The block drives a compare-hit pulse and a set of periodic tap pulses back into the real-time domain.

Starting or stopping the counter, and a soft reset, each cross into the real-time domain through a toggle handshake. Each crossing shows a busy flag that software can poll. The counter value reaches the bus side through a snapshot handshake that refreshes all the time. A control bit chooses, at any moment, between that coherent snapshot and the raw counter bits.

Top module: `rtcc_top`

## Requirements
- R1: The register map is: address 0 control, address 1 compare, address 2 count, address 3 status. Control holds soft reset at bit 0, enable at bit 1, clear-on-match at bit 2, the prescaler code at bits 7:4 and read-sync at bit 8. Status holds reset-busy at bit 0 and enable-busy at bit 1. Control, compare and status all read 0 after the hardware reset.
- R2: Prescaler codes 0 and 1 advance the counter on every real-time clock. A code k from 2 to 11 advances it every 2^(k-1) clocks. The reserved codes 12 to 15 act as a divide by 1024, and they read back as written.
- R3: With clear-on-match set and compare value C, the counter runs 0..C and then returns to 0, so a compare hit repeats every (C+1) ticks. With clear-on-match clear, the counter runs past C and hits only once.
- R4: While counting with a nonzero prescaler code, tap i pulses for one real-time clock every 2^(i+1) clocks, and no two taps pulse together. With code 0, or while stopped, no tap pulses.
- R5: A control write that changes the enable bit reads back the new value on the next bus cycle. Status bit 1 sets at the same moment and clears once the real-time domain has applied the change. Counting and compare hits start and stop to match.
- R6: A control write with bit 0 set clears control, compare and the counter, and stops counting. The other fields of that write are discarded. Control bit 0 and status bit 0 read 1 until the reset has completed in the real-time domain, and then read 0.
- R7: While status bit 0 is set, writes to any register are ignored.
- R8: A control write with bit 0 clear starts no reset: status bit 0 stays 0.
- R9: While enabled, writes to the prescaler and clear-on-match fields are ignored. Read-sync accepts writes at any time.
- R10: With read-sync set, address 2 returns a synchronized copy of the counter. Once counting has stopped, this copy settles to the final count, and the raw read (read-sync clear) returns the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Bus-side clock |
| bus_rst_n | input | 1 | Bus-side synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one bus cycle per write |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| rtc_clk | input | 1 | Real-time counting clock |
| rtc_rst_n | input | 1 | Real-time-side synchronous active-low reset |
| per_tap | output | 8 | Periodic tap pulses, real-time domain |
| cmp0_hit | output | 1 | Compare hit pulse, real-time domain |

## Verification
A register write is visible on the next bus cycle, so the bench reads back at the falling edge right after the write edge. Busy flags clear after an unknown number of cycles of both clocks, so the bench polls status with a bounded poll instead of a fixed delay. Every divide-dependent result is measured as the distance, in real-time clocks, between two successive pulses, sampled on falling real-time edges. That distance does not depend on handshake latency and can be compared exactly. Snapshot reads are taken only after counting has stopped and enough real-time clocks have passed for the snapshot loop to refresh.

// File: rtl/rtcc_pkg.sv
// Shared constants and helpers for the prescaled real-time counter.
// Assumes: one 32-bit data width on the bus, 2-bit register address.
package rtcc_pkg;
    localparam int ADDR_W   = 2;
    localparam int PRESC_W  = 4;
    localparam int MAX_SHIFT = 10;
    localparam int DIV_W    = MAX_SHIFT;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_CMP  = 2'd1;
    localparam logic [ADDR_W-1:0] A_CNT  = 2'd2;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd3;

    localparam int B_SWRST  = 0;
    localparam int B_EN     = 1;
    localparam int B_CLR    = 2;
    localparam int B_PRESC  = 4;
    localparam int B_RDSYNC = 8;

    // Map a prescaler code to a log2 divide; reserved codes saturate.
    function automatic logic [3:0] presc_shift(input logic [PRESC_W-1:0] code);
        if (code <= 4'd1)       return 4'd0;
        else if (code <= 4'd11) return code - 4'd1;
        else                    return 4'(MAX_SHIFT);
    endfunction
endpackage

// File: rtl/rtcc_sync.sv
// Two-flop synchronizer for W independent single-bit level or toggle signals.
// Assumes: each bit changes at most once per several destination clocks.
module rtcc_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two-stage capture into the destination domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/rtcc_bus_regs.sv
// Bus-domain register file: control, compare, status and count readback.
// Raises toggle requests for enable and soft reset. Busy is derived from
// request-versus-synchronized-acknowledge. Receives count snapshots.
// Assumes: snap_val_a is held stable while its request toggle is unacknowledged.
module rtcc_bus_regs
    import rtcc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [CNT_W-1:0]   wdata,
    output logic [CNT_W-1:0]   rdata,
    output logic               ctl_en,
    output logic               ctl_clr,
    output logic [PRESC_W-1:0] ctl_presc,
    output logic [CNT_W-1:0]   cmp_val,
    output logic               en_req,
    output logic               rst_req,
    output logic               snap_ack,
    input  logic               en_ack_a,
    input  logic               rst_ack_a,
    input  logic               snap_req_a,
    input  logic [CNT_W-1:0]   snap_val_a,
    input  logic [CNT_W-1:0]   raw_cnt_a,
    output logic               en_busy,
    output logic               rst_busy
);
    logic             rdsync;
    logic [CNT_W-1:0] cnt_copy;
    logic [2:0]       s;
    logic             snap_new;
    logic             ctrl_wr;
    logic             cmp_wr;

    rtcc_sync #(.W(3)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({snap_req_a, rst_ack_a, en_ack_a}),
        .q     (s)
    );

    // Handshake status decoded from request and returned acknowledge.
    always_comb begin
        en_busy  = en_req ^ s[0];
        rst_busy = rst_req ^ s[1];
        snap_new = s[2] ^ snap_ack;
        ctrl_wr  = wr && !rst_busy && (addr == A_CTRL);
        cmp_wr   = wr && !rst_busy && (addr == A_CMP);
    end

    // Register updates; soft reset wins over every other field of the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_en    <= 1'b0;
            ctl_clr   <= 1'b0;
            ctl_presc <= '0;
            rdsync    <= 1'b0;
            cmp_val   <= '0;
            cnt_copy  <= '0;
            en_req    <= 1'b0;
            rst_req   <= 1'b0;
            snap_ack  <= 1'b0;
        end else begin
            if (snap_new) begin
                cnt_copy <= snap_val_a;
                snap_ack <= s[2];
            end
            if (cmp_wr) begin
                cmp_val <= wdata;
            end
            if (ctrl_wr) begin
                if (wdata[B_SWRST]) begin
                    ctl_en    <= 1'b0;
                    ctl_clr   <= 1'b0;
                    ctl_presc <= '0;
                    rdsync    <= 1'b0;
                    cmp_val   <= '0;
                    cnt_copy  <= '0;
                    rst_req   <= ~rst_req;
                end else begin
                    rdsync <= wdata[B_RDSYNC];
                    if (!ctl_en) begin
                        ctl_clr   <= wdata[B_CLR];
                        ctl_presc <= wdata[B_PRESC +: PRESC_W];
                    end
                    if (!en_busy && (wdata[B_EN] != ctl_en)) begin
                        ctl_en <= wdata[B_EN];
                        en_req <= ~en_req;
                    end
                end
            end
        end
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[B_SWRST]             = rst_busy;
                rdata[B_EN]                = ctl_en;
                rdata[B_CLR]               = ctl_clr;
                rdata[B_PRESC +: PRESC_W]  = ctl_presc;
                rdata[B_RDSYNC]            = rdsync;
            end
            A_CMP:  rdata = cmp_val;
            A_CNT:  rdata = rdsync ? cnt_copy : raw_cnt_a;
            default: begin
                rdata[0] = rst_busy;
                rdata[1] = en_busy;
            end
        endcase
    end
endmodule

// File: rtl/rtcc_core.sv
// Real-time-domain core: answers the enable and reset handshakes, runs the
// prescaler divider, counter, compare match, periodic taps and snapshots.
// Assumes: presc, clr and cmp are quasi-static (changed only while stopped).
module rtcc_core
    import rtcc_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int TAP_N = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_val_a,
    input  logic               en_req_a,
    input  logic               rst_req_a,
    input  logic               snap_ack_a,
    input  logic [PRESC_W-1:0] presc,
    input  logic               clr,
    input  logic [CNT_W-1:0]   cmp,
    output logic               en_ack,
    output logic               rst_ack,
    output logic               snap_req,
    output logic [CNT_W-1:0]   snap_val,
    output logic [CNT_W-1:0]   count,
    output logic               run,
    output logic [TAP_N-1:0]   per_tap,
    output logic               hit
);
    logic [2:0]       s;
    logic             en_edge;
    logic             rst_edge;
    logic [DIV_W-1:0] div;
    logic [DIV_W-1:0] div_prev;
    logic [DIV_W-1:0] mask;
    logic             tick;
    logic             tap_gate;

    rtcc_sync #(.W(3)) u_req_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({snap_ack_a, rst_req_a, en_req_a}),
        .q     (s)
    );

    // Detect pending requests and the divider tick condition.
    always_comb begin
        en_edge  = s[0] ^ en_ack;
        rst_edge = s[1] ^ rst_ack;
        mask     = (DIV_W'(1) << presc_shift(presc)) - DIV_W'(1);
        tick     = run && ((div & mask) == mask);
        hit      = tick && (count == cmp);
        tap_gate = run && (presc != '0);
    end

    // Apply enable and reset requests and return acknowledges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_ack  <= 1'b0;
            rst_ack <= 1'b0;
            run     <= 1'b0;
        end else begin
            en_ack  <= s[0];
            rst_ack <= s[1];
            if (rst_edge)     run <= 1'b0;
            else if (en_edge) run <= en_val_a;
        end
    end

    // Free-running prescaler divider, held at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_edge) begin
            div      <= '0;
            div_prev <= '0;
        end else begin
            div      <= run ? div + DIV_W'(1) : '0;
            div_prev <= div;
        end
    end

    // Counter with optional clear on compare match.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_edge) begin
            count <= '0;
        end else if (tick) begin
            count <= (clr && (count == cmp)) ? '0 : count + CNT_W'(1);
        end
    end

    // Snapshot loop: capture a new count each time the bus side acknowledges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_req <= 1'b0;
            snap_val <= '0;
        end else if (snap_req == s[2]) begin
            snap_val <= count;
            snap_req <= ~snap_req;
        end
    end

    // One tap per divider bit, pulsing on that bit's rising edge.
    for (genvar i = 0; i < TAP_N; i++) begin : g_tap
        assign per_tap[i] = tap_gate && div[i] && !div_prev[i];
    end
endmodule

// File: rtl/rtcc_top.sv
// Top of the prescaled real-time counter: bus-domain registers plus
// real-time-domain counting core, joined by toggle handshakes.
// Assumes: TAP_N does not exceed the divider width.
module rtcc_top
    import rtcc_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int TAP_N = 8
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              rtc_clk,
    input  logic              rtc_rst_n,
    output logic [TAP_N-1:0]  per_tap,
    output logic              cmp0_hit
);
    logic               ctl_en;
    logic               ctl_clr;
    logic [PRESC_W-1:0] ctl_presc;
    logic [CNT_W-1:0]   cmp_val;
    logic               en_req;
    logic               rst_req;
    logic               snap_ack;
    logic               en_ack;
    logic               rst_ack;
    logic               snap_req;
    logic [CNT_W-1:0]   snap_val;
    logic [CNT_W-1:0]   count;
    logic               run;
    logic               en_busy;
    logic               rst_busy;

    rtcc_bus_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (bus_clk),
        .rst_n      (bus_rst_n),
        .wr         (bus_wr),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .rdata      (bus_rdata),
        .ctl_en     (ctl_en),
        .ctl_clr    (ctl_clr),
        .ctl_presc  (ctl_presc),
        .cmp_val    (cmp_val),
        .en_req     (en_req),
        .rst_req    (rst_req),
        .snap_ack   (snap_ack),
        .en_ack_a   (en_ack),
        .rst_ack_a  (rst_ack),
        .snap_req_a (snap_req),
        .snap_val_a (snap_val),
        .raw_cnt_a  (count),
        .en_busy    (en_busy),
        .rst_busy   (rst_busy)
    );

    rtcc_core #(.CNT_W(CNT_W), .TAP_N(TAP_N)) u_core (
        .clk        (rtc_clk),
        .rst_n      (rtc_rst_n),
        .en_val_a   (ctl_en),
        .en_req_a   (en_req),
        .rst_req_a  (rst_req),
        .snap_ack_a (snap_ack),
        .presc      (ctl_presc),
        .clr        (ctl_clr),
        .cmp        (cmp_val),
        .en_ack     (en_ack),
        .rst_ack    (rst_ack),
        .snap_req   (snap_req),
        .snap_val   (snap_val),
        .count      (count),
        .run        (run),
        .per_tap    (per_tap),
        .hit        (cmp0_hit)
    );
endmodule

// File: rtl/rtcc_checker.sv
// Property checker for rtcc_top, attached by bind below.
// Assumes: bus and real-time resets are both applied at start-up.
module rtcc_checker
    import rtcc_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int TAP_N = 8
) (
    input logic               bus_clk,
    input logic               bus_rst_n,
    input logic               rtc_clk,
    input logic               rtc_rst_n,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [CNT_W-1:0]   bus_wdata,
    input logic               ctl_en,
    input logic               ctl_clr,
    input logic [PRESC_W-1:0] ctl_presc,
    input logic [CNT_W-1:0]   cmp_val,
    input logic               en_busy,
    input logic               rst_busy,
    input logic               run,
    input logic [TAP_N-1:0]   per_tap,
    input logic               cmp0_hit,
    input logic [CNT_W-1:0]   count
);
    logic plain_ctrl_wr;
    assign plain_ctrl_wr = bus_wr && (bus_addr == A_CTRL) && !bus_wdata[B_SWRST] && !rst_busy;

    AST_EN_READBACK: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        plain_ctrl_wr && !en_busy |=> ctl_en == $past(bus_wdata[B_EN])); // R5
    AST_EN_BUSY_SET: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        plain_ctrl_wr && !en_busy && (bus_wdata[B_EN] != ctl_en) |=> en_busy); // R5
    AST_RST_CLEARS: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        bus_wr && (bus_addr == A_CTRL) && bus_wdata[B_SWRST] && !rst_busy
        |=> rst_busy && !ctl_en && (cmp_val == '0) && (ctl_presc == '0)); // R6
    AST_IGNORE_IN_RST: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        rst_busy && bus_wr |=> $stable(cmp_val) && $stable(ctl_presc) && $stable(ctl_clr)); // R7
    AST_PROTECTED: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        plain_ctrl_wr && ctl_en |=> $stable(ctl_presc) && $stable(ctl_clr)); // R9
    AST_TAP_ONEHOT: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
        $onehot0(per_tap)); // R4
    AST_QUIET_STOPPED: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
        !run |-> (per_tap == '0) && !cmp0_hit); // R4
    AST_CLR_ON_MATCH: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
        cmp0_hit && ctl_clr |=> count == '0); // R3
endmodule

bind rtcc_top rtcc_checker #(.CNT_W(CNT_W), .TAP_N(TAP_N)) chk_i (
    .bus_clk   (bus_clk),
    .bus_rst_n (bus_rst_n),
    .rtc_clk   (rtc_clk),
    .rtc_rst_n (rtc_rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ctl_en    (ctl_en),
    .ctl_clr   (ctl_clr),
    .ctl_presc (ctl_presc),
    .cmp_val   (cmp_val),
    .en_busy   (en_busy),
    .rst_busy  (rst_busy),
    .run       (run),
    .per_tap   (per_tap),
    .cmp0_hit  (cmp0_hit),
    .count     (count)
);

// File: tb/rtcc_top_tb_top.sv
// Self-checking bench for rtcc_top: sweeps every prescaler code and every tap.
// It measures pulse spacing in real-time clocks and exercises the register rules.
module rtcc_top_tb_top;
    logic        bus_clk = 1'b0;
    logic        rtc_clk = 1'b0;
    logic        bus_rst_n = 1'b0;
    logic        rtc_rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  per_tap;
    logic        cmp0_hit;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5  bus_clk = ~bus_clk;
    always #15 rtc_clk = ~rtc_clk;

    rtcc_top dut_i (
        .bus_clk   (bus_clk),
        .bus_rst_n (bus_rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rtc_clk   (rtc_clk),
        .rtc_rst_n (rtc_rst_n),
        .per_tap   (per_tap),
        .cmp0_hit  (cmp0_hit)
    );

    function automatic logic [31:0] cw(input bit en, input bit clr, input int presc, input bit rds);
        logic [31:0] w = '0;
        w[1]   = en;
        w[2]   = clr;
        w[7:4] = presc[3:0];
        w[8]   = rds;
        return w;
    endfunction

    function automatic int exp_div(input int code);
        if (code <= 1)  return 1;
        if (code <= 11) return 1 << (code - 1);
        return 1024;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge bus_clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge bus_clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] st;
        bit idle = 1'b0;
        for (int k = 0; k < 200; k++) begin
            @(negedge bus_clk);
            bus_read(2'd3, st);
            if (st == 0) begin
                idle = 1'b1;
                break;
            end
        end
        check(idle, req, idle, 1);
    endtask

    task automatic hit_interval(output int iv);
        int first = -1;
        iv = -1;
        for (int n = 0; n < 4000; n++) begin
            @(negedge rtc_clk);
            if (cmp0_hit) begin
                if (first < 0) first = n;
                else begin
                    iv = n - first;
                    break;
                end
            end
        end
    endtask

    task automatic tap_interval(input int idx, output int iv);
        int first = -1;
        iv = -1;
        for (int n = 0; n < 2000; n++) begin
            @(negedge rtc_clk);
            if (per_tap[idx]) begin
                if (first < 0) first = n;
                else begin
                    iv = n - first;
                    break;
                end
            end
        end
    endtask

    task automatic count_pulses(input int cycles, output int taps, output int hits);
        taps = 0;
        hits = 0;
        for (int n = 0; n < cycles; n++) begin
            @(negedge rtc_clk);
            if (per_tap != 0) taps++;
            if (cmp0_hit) hits++;
        end
    endtask

    initial begin
        #1500000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] v1;
        int iv;
        int tp;
        int ht;

        repeat (6) @(negedge rtc_clk);
        bus_rst_n = 1'b1;
        rtc_rst_n = 1'b1;
        repeat (4) @(negedge bus_clk);

        // R1: reset values
        bus_read(2'd0, d); check(d == 0, "R1 ctrl reset", d, 0);
        bus_read(2'd1, d); check(d == 0, "R1 cmp reset", d, 0);
        bus_read(2'd3, d); check(d == 0, "R1 status reset", d, 0);
        check(per_tap == 0, "R1 taps quiet", per_tap, 0);

        // R5: enable readback, busy flag, start and stop
        bus_write(2'd1, 32'd0);
        bus_write(2'd0, cw(1, 1, 1, 0));
        bus_read(2'd0, d); check(d[1] == 1'b1, "R5 enable readback", d[1], 1);
        bus_read(2'd3, d); check(d == 32'd2, "R5 enable busy set", d, 2);
        wait_idle("R5 enable busy clears");
        count_pulses(20, tp, ht); check(ht == 20, "R5 counting after enable", ht, 20);
        bus_write(2'd0, cw(0, 1, 1, 0));
        bus_read(2'd3, d); check(d == 32'd2, "R5 disable busy set", d, 2);
        wait_idle("R5 disable busy clears");
        count_pulses(50, tp, ht); check(ht == 0, "R5 no hits when stopped", ht, 0);

        // R2: every prescaler code, hit spacing with compare 0 and clear set
        for (int c = 0; c < 16; c++) begin
            bus_write(2'd0, cw(1, 1, c, 0));
            bus_read(2'd0, d);
            check(d == cw(1, 1, c, 0), "R2 prescaler readback", d, cw(1, 1, c, 0));
            wait_idle("R2 enable idle");
            hit_interval(iv);
            check(iv == exp_div(c), $sformatf("R2 divide for code %0d", c), iv, exp_div(c));
            bus_write(2'd0, cw(0, 1, c, 0));
            wait_idle("R2 disable idle");
        end

        // R3: clear on match with compare 2, divide by 2
        bus_write(2'd1, 32'd2);
        bus_write(2'd0, cw(1, 1, 2, 0));
        wait_idle("R3 enable idle");
        hit_interval(iv); check(iv == 6, "R3 wrap spacing", iv, 6);
        bus_write(2'd0, cw(0, 1, 2, 0));
        wait_idle("R3 disable idle");

        // R3 and R10: run past compare 5, then read synchronized count
        bus_write(2'd1, 32'd5);
        bus_write(2'd0, cw(1, 0, 1, 1));
        wait_idle("R3 enable idle");
        count_pulses(300, tp, ht); check(ht == 1, "R3 single hit without clear", ht, 1);
        bus_write(2'd0, cw(0, 0, 1, 1));
        wait_idle("R10 disable idle");
        repeat (40) @(negedge rtc_clk);
        @(negedge bus_clk);
        bus_read(2'd2, v1); check(v1 >= 32'd300, "R3 count runs past compare", v1, 300);
        repeat (40) @(negedge rtc_clk);
        @(negedge bus_clk);
        bus_read(2'd2, d); check(d == v1, "R10 synced count stable", d, v1);
        bus_write(2'd0, cw(0, 0, 1, 0));
        bus_read(2'd2, d); check(d == v1, "R10 raw equals synced", d, v1);

        // R4: tap spacing with prescaler code 3
        bus_write(2'd0, cw(1, 0, 3, 0));
        wait_idle("R4 enable idle");
        for (int i = 0; i < 8; i++) begin
            tap_interval(i, iv);
            check(iv == (2 << i), $sformatf("R4 tap %0d spacing", i), iv, 2 << i);
        end
        bus_write(2'd0, cw(0, 0, 3, 0));
        wait_idle("R4 disable idle");
        count_pulses(100, tp, ht); check(tp == 0, "R4 no taps when stopped", tp, 0);
        bus_write(2'd0, cw(1, 0, 0, 0));
        wait_idle("R4 enable idle");
        count_pulses(600, tp, ht); check(tp == 0, "R4 no taps with code 0", tp, 0);
        bus_write(2'd0, cw(0, 0, 0, 0));
        wait_idle("R4 disable idle");

        // R9: protected fields while enabled, read-sync writable
        bus_write(2'd0, cw(1, 0, 3, 0));
        wait_idle("R9 enable idle");
        bus_write(2'd0, cw(1, 1, 5, 1));
        bus_read(2'd0, d); check(d == cw(1, 0, 3, 1), "R9 protected fields held", d, cw(1, 0, 3, 1));
        bus_read(2'd3, d); check(d == 0, "R9 no busy on same enable", d, 0);

        // R6 and R7: soft reset discards fields, blocks writes until done
        bus_write(2'd1, 32'd9);
        bus_write(2'd0, cw(1, 1, 7, 1) | 32'd1);
        bus_read(2'd0, d); check(d == 32'd1, "R6 reset bit and cleared fields", d, 1);
        bus_write(2'd1, 32'h77);
        bus_read(2'd3, d); check(d[0] == 1'b1, "R7 still resetting at write", d[0], 1);
        bus_write(2'd0, cw(1, 1, 6, 1));
        wait_idle("R6 reset busy clears");
        bus_read(2'd0, d); check(d == 0, "R7 ctrl write ignored, R6 ctrl cleared", d, 0);
        bus_read(2'd1, d); check(d == 0, "R7 cmp write ignored, R6 cmp cleared", d, 0);
        count_pulses(100, tp, ht); check(ht == 0 && tp == 0, "R6 stopped after reset", ht + tp, 0);

        // R8: write with reset bit clear, then check the counter was cleared
        bus_write(2'd0, cw(0, 0, 0, 1));
        bus_read(2'd3, d); check(d == 0, "R8 no reset started", d, 0);
        bus_read(2'd0, d); check(d == cw(0, 0, 0, 1), "R8 ctrl written", d, cw(0, 0, 0, 1));
        repeat (40) @(negedge rtc_clk);
        @(negedge bus_clk);
        bus_read(2'd2, d); check(d == 0, "R6 counter cleared", d, 0);

        done = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule